// File: doc/BRIEF.md
# Variable Partition Placement Selector

This block manages a small table of free memory regions. Each valid entry holds a start address and a length. An allocation request names a size and one of four placement policies. The block scans the table one entry per clock, picks a region under that policy, and returns the region's start address. The chosen entry then shrinks: its start advances by the size and its length drops by the size. A release request places a new free region into the table. Neighbouring free regions are not merged on release. Compaction and swapping are left to the software around the block.

Requests use a single request/grant handshake. A request is taken only while `busy` is low. The grant is a one-cycle pulse on `gnt_valid`, and `gnt_fail` tells success from failure. The controller is a three-state machine:

- `ST_IDLE`: waiting for a request.
- `ST_SCAN`: reading one table entry per cycle.
- `ST_DONE`: presenting the grant and committing the table update.

The transitions are:

- ST_IDLE to ST_SCAN on an accepted allocation of non-zero size.
- ST_IDLE to ST_DONE on an accepted release or a zero-size allocation.
- ST_SCAN to ST_DONE when a first-fit or next-fit scan hits, or when the last of the N entries has been visited.
- ST_DONE to ST_IDLE always, after exactly one cycle.

Top module: `place_sel`

## Requirements
- R1: After reset every table entry is invalid, `busy` and `gnt_valid` are 0, the next-fit pointer is entry 0, and an allocation fails.
- R2: Mode 0 (first-fit) scans from entry 0 upward and takes the lowest-index valid entry whose length is at least the requested size.
- R3: Mode 1 (best-fit) visits all entries and takes the valid entry with the smallest length not below the size. A tie goes to the lowest index.
- R4: Mode 2 (worst-fit) visits all entries and takes the valid entry with the largest length. A tie goes to the lowest index. The request fails if that largest length is below the size.
- R5: Mode 3 (next-fit) starts its scan at the entry of the most recent successful allocation, made in any mode. It wraps from entry N-1 to entry 0 and takes the first entry that fits. It stops after visiting N entries.
- R6: On a successful allocation, `gnt_addr` is the chosen entry's start. The entry keeps start+size (modulo 2^DW) and length-size. If the remainder is zero, the entry becomes invalid.
- R7: An allocation with size 0, or one that no entry fits, grants with `gnt_fail`=1 and leaves the table and the next-fit pointer unchanged.
- R8: A release (`req_release`=1, start on `req_addr`, length on `req_size`) writes the lowest-index invalid entry and echoes the start on `gnt_addr`. It fails, leaving the table unchanged, if the length is 0 or no entry is invalid.
- R9: A request is accepted only when `busy` is 0. `busy` is high from the cycle after acceptance through the grant cycle. `gnt_valid` lasts exactly one cycle. `req_valid` while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_release | input | 1 | 1 = release a region, 0 = allocate |
| req_mode | input | 2 | Placement policy: 0 first, 1 best, 2 worst, 3 next |
| req_size | input | DW | Allocation size, or release length |
| req_addr | input | DW | Start address of a released region |
| busy | output | 1 | Request in progress |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_fail | output | 1 | Grant outcome: 1 = failed |
| gnt_addr | output | DW | Allocated start, or echoed release start |

## Verification
The bench sweeps every mode against every size from 0 to 21. Each sweep point starts from a freshly reset table holding lengths 9, 3, 9 and 14. These values separate the policies, because first-fit, best-fit and worst-fit pick different entries, and the two equal lengths expose tie handling. Each sweep point issues two back-to-back allocations. The second one shows the shrunk entries, the zero-remainder removal and the next-fit pointer at work.

A long pseudo-random phase then mixes releases (including zero length and a full table) with allocations in all modes. Some of these carry stray requests raised while busy. An arithmetic model in the bench predicts every grant outcome and address.

// File: rtl/pl_pkg.sv
package pl_pkg;

    typedef enum logic [1:0] {
        FIT_FIRST = 2'd0,
        FIT_BEST  = 2'd1,
        FIT_WORST = 2'd2,
        FIT_NEXT  = 2'd3
    } fit_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DONE
    } scan_state_e;

endpackage

// File: rtl/pl_table.sv
module pl_table #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int IW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IW-1:0]          rd_idx,
    output logic                   rd_valid,
    output logic [DW-1:0]          rd_start,
    output logic [DW-1:0]          rd_len,
    output logic                   free_found,
    input  logic                   alloc_en,
    input  logic [IW-1:0]          alloc_idx,
    input  logic [DW-1:0]          alloc_size,
    input  logic                   ins_en,
    input  logic [DW-1:0]          ins_start,
    input  logic [DW-1:0]          ins_len,
    output logic [N*(2*DW+1)-1:0]  snap
);
    localparam int EW = 2 * DW + 1;

    logic [N-1:0]  vl_q;
    logic [DW-1:0] st_q [N];
    logic [DW-1:0] ln_q [N];
    logic [IW-1:0] free_idx;

    // lowest invalid entry receives a released region
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vl_q[i]) free_idx = IW'(i);
        end
    end
    assign free_found = ~&vl_q;

    assign rd_valid = vl_q[rd_idx];
    assign rd_start = st_q[rd_idx];
    assign rd_len   = ln_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                vl_q[i] <= 1'b0;
                st_q[i] <= '0;
                ln_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (alloc_en && alloc_idx == IW'(i)) begin
                    st_q[i] <= st_q[i] + alloc_size;
                    ln_q[i] <= ln_q[i] - alloc_size;
                    if (ln_q[i] == alloc_size) vl_q[i] <= 1'b0;
                end else if (ins_en && free_idx == IW'(i)) begin
                    vl_q[i] <= 1'b1;
                    st_q[i] <= ins_start;
                    ln_q[i] <= ins_len;
                end
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_ent
        assign snap[g*EW +: EW] = {vl_q[g], st_q[g], ln_q[g]};

        // R6
        len_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vl_q[g] |-> (ln_q[g] != '0));
    end

endmodule

// File: rtl/pl_scan.sv
module pl_scan
    import pl_pkg::*;
#(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_release,
    input  logic [1:0]    req_mode,
    input  logic [DW-1:0] req_size,
    input  logic [DW-1:0] req_addr,
    output logic [IW-1:0] rd_idx,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_start,
    input  logic [DW-1:0] rd_len,
    input  logic          free_found,
    output logic          alloc_en,
    output logic [IW-1:0] alloc_idx,
    output logic [DW-1:0] alloc_size,
    output logic          ins_en,
    output logic [DW-1:0] ins_start,
    output logic [DW-1:0] ins_len,
    output logic          busy,
    output logic          gnt_valid,
    output logic          gnt_fail,
    output logic [DW-1:0] gnt_addr
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    scan_state_e   state_q, state_d;
    fit_mode_e     mode_q;
    logic [DW-1:0] size_q, addr_q, sel_len_q, sel_start_q;
    logic          rel_q, found_q;
    logic [IW-1:0] idx_q, cnt_q, sel_q, rover_q;

    logic accept, fits, take, hit_early, scan_end, ok;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign fits      = rd_valid && (rd_len >= size_q);
    assign scan_end  = (cnt_q == LAST);
    assign hit_early = ((mode_q == FIT_FIRST) || (mode_q == FIT_NEXT)) && fits;

    always_comb begin
        unique case (mode_q)
            FIT_BEST:  take = fits && (!found_q || rd_len < sel_len_q);
            FIT_WORST: take = rd_valid && (!found_q || rd_len > sel_len_q);
            default:   take = fits;
        endcase
    end

    assign ok = rel_q ? found_q : (found_q && sel_len_q >= size_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = (req_release || req_size == '0) ? ST_DONE : ST_SCAN;
            ST_SCAN: if (hit_early || scan_end) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // request capture and scan datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= FIT_FIRST;
            size_q      <= '0;
            addr_q      <= '0;
            rel_q       <= 1'b0;
            found_q     <= 1'b0;
            sel_len_q   <= '0;
            sel_start_q <= '0;
            idx_q       <= '0;
            cnt_q       <= '0;
            sel_q       <= '0;
            rover_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    mode_q      <= fit_mode_e'(req_mode);
                    size_q      <= req_size;
                    addr_q      <= req_addr;
                    rel_q       <= req_release;
                    found_q     <= req_release && free_found && (req_size != '0);
                    sel_len_q   <= '0;
                    sel_start_q <= '0;
                    sel_q       <= '0;
                    cnt_q       <= '0;
                    idx_q       <= (fit_mode_e'(req_mode) == FIT_NEXT) ? rover_q : '0;
                end
                ST_SCAN: begin
                    if (take) begin
                        found_q     <= 1'b1;
                        sel_q       <= idx_q;
                        sel_len_q   <= rd_len;
                        sel_start_q <= rd_start;
                    end
                    idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_DONE: if (alloc_en) rover_q <= sel_q;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        gnt_valid  = (state_q == ST_DONE);
        gnt_fail   = !ok;
        gnt_addr   = rel_q ? addr_q : sel_start_q;
        alloc_en   = (state_q == ST_DONE) && !rel_q && ok;
        alloc_idx  = sel_q;
        alloc_size = size_q;
        ins_en     = (state_q == ST_DONE) && rel_q && ok;
        ins_start  = addr_q;
        ins_len    = size_q;
        rd_idx     = (state_q == ST_DONE) ? sel_q : idx_q;
    end

    // R9
    gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> !gnt_valid);

    // R2
    sel_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !rel_q && !gnt_fail) |-> (rd_valid && rd_len >= size_q));

    // R7
    zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !rel_q && size_q == '0) |-> gnt_fail);

endmodule

// File: rtl/place_sel.sv
module place_sel #(
    parameter int N  = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_release,
    input  logic [1:0]    req_mode,
    input  logic [DW-1:0] req_size,
    input  logic [DW-1:0] req_addr,
    output logic          busy,
    output logic          gnt_valid,
    output logic          gnt_fail,
    output logic [DW-1:0] gnt_addr
);
    localparam int IW = (N < 2) ? 1 : $clog2(N);

    logic [IW-1:0]          rd_idx, alloc_idx;
    logic                   rd_valid, free_found, alloc_en, ins_en;
    logic [DW-1:0]          rd_start, rd_len, alloc_size, ins_start, ins_len;
    logic [N*(2*DW+1)-1:0]  snap;

    pl_scan #(.N(N), .DW(DW), .IW(IW)) u_scan (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_release(req_release), .req_mode(req_mode),
        .req_size(req_size), .req_addr(req_addr),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_start(rd_start), .rd_len(rd_len),
        .free_found(free_found),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_size(alloc_size),
        .ins_en(ins_en), .ins_start(ins_start), .ins_len(ins_len),
        .busy(busy), .gnt_valid(gnt_valid), .gnt_fail(gnt_fail), .gnt_addr(gnt_addr)
    );

    pl_table #(.N(N), .DW(DW), .IW(IW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_start(rd_start), .rd_len(rd_len),
        .free_found(free_found),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_size(alloc_size),
        .ins_en(ins_en), .ins_start(ins_start), .ins_len(ins_len),
        .snap(snap)
    );

    // R7
    fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && gnt_fail) |=> $stable(snap));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

endmodule

// File: tb/sim_place_sel.sv
`timescale 1ns/1ps
module sim_place_sel;
    localparam int N  = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_release = 1'b0;
    logic [1:0]    req_mode = 2'd0;
    logic [DW-1:0] req_size = '0;
    logic [DW-1:0] req_addr = '0;
    logic          busy, gnt_valid, gnt_fail;
    logic [DW-1:0] gnt_addr;

    int checks = 0;
    int errors = 0;
    logic [15:0] seed = 16'hACE1;

    int ms [N];
    int ml [N];
    bit mv [N];
    int mrov;

    always #2.5 clk = ~clk;

    place_sel #(.N(N), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_release(req_release),
        .req_mode(req_mode), .req_size(req_size), .req_addr(req_addr),
        .busy(busy), .gnt_valid(gnt_valid), .gnt_fail(gnt_fail), .gnt_addr(gnt_addr)
    );

    function automatic int rnd();
        seed = {seed[14:0], seed[15] ^ seed[13] ^ seed[12] ^ seed[10]};
        return int'(seed);
    endfunction

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin ms[i] = 0; ml[i] = 0; mv[i] = 0; end
        mrov = 0;
    endtask

    task automatic model_alloc(input int mode, input int size, output bit ok, output int addr);
        int pick;
        pick = -1;
        addr = 0;
        if (size != 0) begin
            case (mode)
                0: for (int i = 0; i < N; i++)
                       if (pick < 0 && mv[i] && ml[i] >= size) pick = i;
                3: for (int k = 0; k < N; k++) begin
                       int j;
                       j = (mrov + k) % N;
                       if (pick < 0 && mv[j] && ml[j] >= size) pick = j;
                   end
                1: for (int i = 0; i < N; i++)
                       if (mv[i] && ml[i] >= size && (pick < 0 || ml[i] < ml[pick])) pick = i;
                default: begin
                    for (int i = 0; i < N; i++)
                        if (mv[i] && (pick < 0 || ml[i] > ml[pick])) pick = i;
                    if (pick >= 0 && ml[pick] < size) pick = -1;
                end
            endcase
        end
        ok = (pick >= 0);
        if (ok) begin
            addr = ms[pick];
            ms[pick] = (ms[pick] + size) & 255;
            ml[pick] = ml[pick] - size;
            if (ml[pick] == 0) mv[pick] = 0;
            mrov = pick;
        end
    endtask

    task automatic model_release(input int start, input int len, output bit ok);
        int slot;
        slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
        ok = (len != 0) && (slot >= 0);
        if (ok) begin mv[slot] = 1; ms[slot] = start; ml[slot] = len; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(gnt_valid == 1'b0, "R1 gnt_valid after reset", int'(gnt_valid), 0);
    endtask

    task automatic do_op(input bit rel, input int mode, input int size, input int addr, input bit inject);
        int n;
        bit eok;
        int eaddr;
        bit gf;
        int ga;
        string tag;
        @(negedge clk);
        req_release = rel;
        req_mode = 2'(mode);
        req_size = DW'(size);
        req_addr = DW'(addr);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        n = 0;
        while (!gnt_valid && n < 100) begin
            if (inject && n == 0) begin
                req_valid = 1'b1;
                req_release = ~rel;
                req_mode = 2'(mode + 1);
                req_size = 8'd1;
                req_addr = 8'hEE;
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk(busy == 1'b1, "R9 busy until grant", int'(busy), 1);
            n++;
        end
        chk(gnt_valid == 1'b1, "R9 grant arrives", int'(gnt_valid), 1);
        gf = gnt_fail;
        ga = int'(gnt_addr);
        @(negedge clk);
        chk(gnt_valid == 1'b0, "R9 grant one cycle", int'(gnt_valid), 0);
        chk(busy == 1'b0, "R9 idle after grant", int'(busy), 0);
        if (rel) begin
            model_release(addr, size, eok);
            chk(gf == !eok, "R8 release outcome", int'(gf), int'(!eok));
            if (eok) chk(ga == addr, "R8 release echo", ga, addr);
        end else begin
            model_alloc(mode, size, eok, eaddr);
            case (mode)
                0: tag = "R2 first-fit outcome";
                1: tag = "R3 best-fit outcome";
                2: tag = "R4 worst-fit outcome";
                default: tag = "R5 next-fit outcome";
            endcase
            if (!eok) tag = {tag, " R7 no-fit"};
            chk(gf == !eok, tag, int'(gf), int'(!eok));
            if (eok) chk(ga == eaddr, "R6 granted start", ga, eaddr);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: empty table refuses an allocation
        do_op(1'b0, 0, 1, 0, 1'b0);
        // R8: fill four entries, fifth refused, zero length refused
        do_op(1'b1, 0, 10, 0, 1'b0);
        do_op(1'b1, 0, 4, 40, 1'b0);
        do_op(1'b1, 0, 7, 80, 1'b0);
        do_op(1'b1, 0, 20, 120, 1'b1);
        do_op(1'b1, 0, 5, 200, 1'b0);
        do_op(1'b1, 0, 0, 210, 1'b0);
        // R2..R5 on a known table
        do_op(1'b0, 1, 5, 0, 1'b0);
        do_op(1'b0, 2, 5, 0, 1'b1);
        do_op(1'b0, 3, 9, 0, 1'b0);
        do_op(1'b0, 0, 4, 0, 1'b0);
        do_op(1'b0, 0, 2, 0, 1'b0);
        do_op(1'b0, 2, 60, 0, 1'b0);

        // exhaustive sweep: mode x size on a fixed table with a tie
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 22; s++) begin
                do_reset();
                do_op(1'b1, 0, 9, 16, 1'b0);
                do_op(1'b1, 0, 3, 48, 1'b0);
                do_op(1'b1, 0, 9, 96, 1'b0);
                do_op(1'b1, 0, 14, 160, 1'b0);
                do_op(1'b0, m, s, 0, 1'b0);
                do_op(1'b0, m, s, 0, (s % 3) == 0);
            end
        end

        // pseudo-random mixed traffic
        do_reset();
        for (int t = 0; t < 3000; t++) begin
            int r;
            r = rnd();
            if ((r % 8) < 3) do_op(1'b1, 0, rnd() % 16, rnd() % 256, (rnd() % 4) == 0);
            else             do_op(1'b0, rnd() % 4, rnd() % 20, 0, (rnd() % 4) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule